// File: doc/BRIEF.md
# Reset Control Port Register

This block is a single byte-wide register that sits on a simple I/O bus at port 0xCF9. Software writes it to ask the platform for a reset and to choose which kind of reset it wants. A write that carries the trigger bit does not change the register. Instead, it produces a one-clock request pulse that the platform reset sequencer consumes. Any other write keeps only the reset-type bit and clears the rest.

A read at the port returns the stored byte and acknowledges in the same cycle. Accesses at any other address are ignored. Such a read returns zero and gets no acknowledge, so a neighbouring decoder can answer it instead. The block only raises the request. The reset sequence itself and the decoding of other ports live elsewhere.

Top module: `rstctl_port`

## Requirements
- R1: After power-on reset the stored byte reads 0x00 and `reset_pulse` is low.
- R2: The block decodes only the full I/O address 0xCF9. Every other address, including ones that differ only in upper address bits, is not decoded.
- R3: A write to 0xCF9 with data bit 2 clear stores only data bit 1 (the reset type). All other stored bits become zero.
- R4: A write to 0xCF9 with data bit 2 set (the trigger) leaves the stored byte unchanged. It drives `reset_pulse` high in the cycle that follows the write edge.
- R5: `reset_pulse` stays high for exactly one clock after each trigger write. It is never high unless a trigger write was accepted on the previous edge.
- R6: A read at 0xCF9 returns the stored byte on `io_rdata` and raises `io_ack` in the same cycle. A write at 0xCF9 also raises `io_ack`.
- R7: A write or read at any other address has no effect on the stored byte or on `reset_pulse`. During it, `io_rdata` is 0x00 and `io_ack` is low.
- R8: When a read and a write to 0xCF9 occur in the same cycle, the read returns the value held before that write. The write takes effect on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one access per cycle |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, zero unless this port is read |
| io_ack | output | 1 | High while an access hits this port |
| reset_pulse | output | 1 | One-clock platform reset request |

## Verification
The bench writes bytes that carry junk in every bit except the type bit. A design that masked the wrong bits would read back something other than 0x02 or 0x00. It sends trigger writes both with and without the type bit already stored. A design that stored the trigger write would change the read-back value, and one that stretched the request would show `reset_pulse` high a second cycle. It aims writes and trigger writes at neighbouring ports and at an alias with a high address bit set. Incomplete decoding would then alter the register or fire a reset. A read and a write in the same cycle exposes a read path taken from the next value instead of the stored one.

// File: rtl/rcp_pkg.sv
package rcp_pkg;
  localparam int unsigned RCP_DW = 8;
  typedef logic [RCP_DW-1:0] rcp_byte_t;

  // stored form of a non-trigger write: only the type bit survives
  function automatic rcp_byte_t rcp_keep_type(input rcp_byte_t d, input int unsigned tbit);
    rcp_byte_t m;
    m = rcp_byte_t'(1) << tbit;
    return d & m;
  endfunction

  // does this write carry the trigger bit
  function automatic logic rcp_is_trigger(input rcp_byte_t d, input int unsigned gbit);
    return d[gbit];
  endfunction
endpackage

// File: rtl/rcp_decode.sv
module rcp_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output logic              rd_hit,
  output logic              wr_hit
);
  logic match;
  assign match  = (addr == PORT_ADDR);
  assign rd_hit = rd & match;
  assign wr_hit = wr & match;
endmodule

// File: rtl/rcp_store.sv
module rcp_store
  import rcp_pkg::*;
#(
  parameter int unsigned TYPE_BIT = 1,
  parameter int unsigned TRIG_BIT = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_hit,
  input  rcp_byte_t wdata,
  output rcp_byte_t reg_q,
  output logic      trig_evt,
  output logic      pulse_q
);
  logic store_evt;
  assign trig_evt  = wr_hit & rcp_is_trigger(wdata, TRIG_BIT);
  assign store_evt = wr_hit & ~trig_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= trig_evt;
      if (store_evt) reg_q <= rcp_keep_type(wdata, TYPE_BIT);
    end
  end
endmodule

// File: rtl/rstctl_port.sv
module rstctl_port
  import rcp_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9,
  parameter int unsigned TYPE_BIT = 1,
  parameter int unsigned TRIG_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              io_ack,
  output logic              reset_pulse
);
  logic      rd_hit;
  logic      wr_hit;
  logic      trig_evt;
  rcp_byte_t reg_q;

  rcp_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_dec (
    .addr(io_addr), .rd(io_rd), .wr(io_wr), .rd_hit(rd_hit), .wr_hit(wr_hit)
  );

  rcp_store #(.TYPE_BIT(TYPE_BIT), .TRIG_BIT(TRIG_BIT)) u_st (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wdata(io_wdata),
    .reg_q(reg_q), .trig_evt(trig_evt), .pulse_q(reset_pulse)
  );

  assign io_rdata = rd_hit ? reg_q : '0;
  assign io_ack   = rd_hit | wr_hit;
endmodule

// File: rtl/rcp_checker.sv
module rcp_checker #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9,
  parameter int unsigned TYPE_BIT = 1,
  parameter int unsigned TRIG_BIT = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              io_ack,
  input logic              reset_pulse,
  input logic [7:0]        reg_q
);
  logic at_port;
  assign at_port = (io_addr == PORT_ADDR);

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    reset_pulse |-> $past(io_wr && at_port && io_wdata[TRIG_BIT])); // R5
  AST_PULSE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && at_port && io_wdata[TRIG_BIT]) |=> reset_pulse); // R4
  AST_TRIG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && at_port && io_wdata[TRIG_BIT]) |=> $stable(reg_q)); // R4
  AST_TYPE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && at_port && !io_wdata[TRIG_BIT]) |=> (reg_q == ($past(io_wdata) & (8'd1 << TYPE_BIT)))); // R3
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !at_port |-> (!io_ack && io_rdata == 8'h00)); // R7
  AST_MISS_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !at_port) |=> ($stable(reg_q) && !reset_pulse)); // R7
  AST_READ_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && at_port) |-> (io_ack && io_rdata == reg_q)); // R6
endmodule

bind rstctl_port rcp_checker #(
  .ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR), .TYPE_BIT(TYPE_BIT), .TRIG_BIT(TRIG_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ack(io_ack),
  .reset_pulse(reset_pulse), .reg_q(reg_q)
);

// File: tb/rstctl_port_tb_top.sv
module rstctl_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        io_ack;
  logic        reset_pulse;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk; // 250 MHz

  rstctl_port dut_i (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ack(io_ack), .reset_pulse(reset_pulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // write at negedge, strobe sampled on next posedge; returns at the negedge after
  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_wdata = '0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] d, output logic k);
    io_addr = a; io_rd = 1'b1;
    #1;
    d = io_rdata; k = io_ack;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d; logic k;
    check(reset_pulse == 1'b0, "R1 pulse after reset", reset_pulse, 0);
    bus_read(16'hCF9, d, k);
    check(d == 8'h00, "R1 stored after reset", d, 0);
    check(k == 1'b1, "R6 ack on read", k, 1);
  endtask

  task automatic t_store;
    logic [7:0] d; logic k;
    bus_write(16'hCF9, 8'hFB);
    check(reset_pulse == 1'b0, "R3 no pulse on store", reset_pulse, 0);
    bus_read(16'hCF9, d, k);
    check(d == 8'h02, "R3 keep type bit of 0xFB", d, 8'h02);
    bus_write(16'hCF9, 8'hF9);
    bus_read(16'hCF9, d, k);
    check(d == 8'h00, "R3 clear from 0xF9", d, 0);
    bus_write(16'hCF9, 8'h02);
    bus_read(16'hCF9, d, k);
    check(d == 8'h02, "R3 store 0x02", d, 8'h02);
  endtask

  task automatic t_trigger;
    logic [7:0] d; logic k;
    // stored 0x02 here
    bus_write(16'hCF9, 8'h04);
    check(reset_pulse == 1'b1, "R4 pulse after trigger", reset_pulse, 1);
    @(negedge clk);
    check(reset_pulse == 1'b0, "R5 pulse one clock", reset_pulse, 0);
    bus_read(16'hCF9, d, k);
    check(d == 8'h02, "R4 stored kept on trigger", d, 8'h02);
    bus_write(16'hCF9, 8'h00);
    bus_write(16'hCF9, 8'hFE);
    check(reset_pulse == 1'b1, "R4 pulse from 0xFE", reset_pulse, 1);
    @(negedge clk);
    check(reset_pulse == 1'b0, "R5 pulse drops", reset_pulse, 0);
    bus_read(16'hCF9, d, k);
    check(d == 8'h00, "R4 stored kept at zero", d, 0);
  endtask

  task automatic t_miss;
    logic [7:0] d; logic k;
    bus_write(16'hCF9, 8'h02);
    bus_write(16'hCF8, 8'h00);
    bus_write(16'hCFA, 8'h00);
    bus_write(16'h1CF9, 8'h00);
    check(reset_pulse == 1'b0, "R7 no pulse on miss", reset_pulse, 0);
    bus_write(16'hCF8, 8'h06);
    check(reset_pulse == 1'b0, "R2 trigger at 0xCF8 ignored", reset_pulse, 0);
    bus_write(16'h8CF9, 8'h04);
    check(reset_pulse == 1'b0, "R2 trigger at alias ignored", reset_pulse, 0);
    bus_read(16'hCF9, d, k);
    check(d == 8'h02, "R7 stored unchanged by misses", d, 8'h02);
    bus_read(16'hCF8, d, k);
    check(d == 8'h00, "R7 miss read data", d, 0);
    check(k == 1'b0, "R7 miss read ack", k, 0);
    bus_read(16'h4CF9, d, k);
    check(k == 1'b0 && d == 8'h00, "R2 alias read no ack", {k, d}, 0);
  endtask

  task automatic t_rdwr;
    logic [7:0] d; logic k;
    // stored 0x02; read and write zero together
    io_addr = 16'hCF9; io_wdata = 8'h00; io_wr = 1'b1; io_rd = 1'b1;
    #1;
    d = io_rdata;
    check(d == 8'h02, "R8 read sees old value", d, 8'h02);
    check(io_ack == 1'b1, "R6 ack on write", io_ack, 1);
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
    bus_read(16'hCF9, d, k);
    check(d == 8'h00, "R8 write lands after edge", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_store();
    t_trigger();
    t_miss();
    t_rdwr();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule